// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two W-bit operands and a carry-in. It does not let a carry ripple from bit to bit. Each bit position first forms a generate term (both bits set) and a propagate term (bits differ). Groups of four bits then resolve their own internal carries in one flat sum-of-products step. Each group also hands a generate/propagate pair upward to a four-input lookahead carry generator. That generator works out the carries entering the groups and its own combined pair. At 64 bits a further generator sits above four such generators. The same two leaf cells, the four-bit group and the four-input generator, make up every supported width.

The sum, the carry-out and a two's-complement overflow flag are captured in output registers on the rising clock edge, so results appear one cycle after the operands. A synchronous active-high reset clears all three outputs. The width parameter accepts 4 (one group), 16 (four groups, one generator) or 64 (sixteen groups, five generators). Any other value stops elaboration.

Top module: `cla_adder`

## Requirements
- R1: On a rising edge with `rst` high, `sum`, `cout` and `ovf` become zero, whatever the operand inputs are.
- R2: On a rising edge with `rst` low, `sum` takes the value (a + b + cin) mod 2^W, computed from the inputs present at that edge, so the result is visible one cycle after the operands.
- R3: `cout` registered at the same edge equals bit W of the (W+1)-bit value a + b + cin.
- R4: `ovf` is 1 exactly when a[W-1] equals b[W-1] and the registered sum's bit W-1 differs from them. This is the same as the carry into bit W-1 XOR the carry out of bit W-1.
- R5: When every bit propagates (a all ones, b zero) and cin is 1, the carry passes through all groups: sum is zero and cout is 1.
- R6: W = 4, 16 and 64 all give results that obey R2 to R4. The 4-bit case uses a single group, and the 64-bit case uses sixteen groups under five lookahead generators.
- R7: The largest positive two's-complement operand plus 1 (cin 0) gives sum = 1 followed by W-1 zeros, ovf = 1 and cout = 0.
- R8: With a = b = 0 and cin = 1, sum is 1 and both cout and ovf are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for the output registers |
| rst | input | 1 | Synchronous active-high reset of the outputs |
| a | input | W | First operand |
| b | input | W | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | W | Registered sum, low W bits |
| cout | output | 1 | Registered carry out of bit W-1 |
| ovf | output | 1 | Registered two's-complement overflow |

## Verification
Some checks run on every evaluation. Each group's lookahead carry-out is checked against a one-step ripple from its bit-3 carry. Each lower group's carry-out must match the carry the generator hierarchy hands to the group above. The top-level group pair must reproduce the final carry. The registered sum, carry and overflow are also compared on every clock against the previous cycle's operands. The bench scenarios are needed for other things: an exhaustive sweep of all 512 input patterns at width 4, the width-dependent corners (full propagation, largest positive plus one, carry-in alone), and a reset asserted mid-stream with operands held at all ones.

// File: rtl/cla_pkg.sv
package cla_pkg;

  // Bits handled by one lookahead group and inputs of one carry generator.
  localparam int GRP_W = 4;

  // Generate / propagate pair exported by a bit group or a generator.
  typedef struct packed {
    logic g;
    logic p;
  } gp_t;

endpackage

// File: rtl/cla_grp4.sv
module cla_grp4
  import cla_pkg::*;
(
  input  logic [GRP_W-1:0] x,
  input  logic [GRP_W-1:0] y,
  input  logic             c0,
  output logic [GRP_W-1:0] s,
  output logic             c3,
  output logic             c4,
  output gp_t              grp
);

  logic [GRP_W-1:0] g;
  logic [GRP_W-1:0] p;
  logic             c1;
  logic             c2;

  assign g = x & y;
  assign p = x ^ y;

  // Every internal carry straight from g, p and c0 in two-level form.
  assign c1 = g[0] | (c0 & p[0]);
  assign c2 = g[1] | (g[0] & p[1]) | (c0 & p[0] & p[1]);
  assign c3 = g[2] | (g[1] & p[2]) | (g[0] & p[1] & p[2])
            | (c0 & p[0] & p[1] & p[2]);
  assign c4 = g[3] | (g[2] & p[3]) | (g[1] & p[2] & p[3])
            | (g[0] & p[1] & p[2] & p[3])
            | (c0 & p[0] & p[1] & p[2] & p[3]);

  assign s = p ^ {c3, c2, c1, c0};

  assign grp.p = &p;
  assign grp.g = g[3] | (g[2] & p[3]) | (g[1] & p[2] & p[3])
               | (g[0] & p[1] & p[2] & p[3]);

  always_comb begin
    if (!$isunknown({x, y, c0})) begin
      // R2
      grp_arith_chk: assert ({c4, s} == ({1'b0, x} + {1'b0, y} + 5'(c0)))
        else $error("group sum/carry differs from arithmetic");
      // R5
      grp_prop_chk: assert (!grp.p || (c4 == c0))
        else $error("propagating group did not pass its carry-in");
    end
  end

endmodule

// File: rtl/cla_lcg4.sv
module cla_lcg4
  import cla_pkg::*;
(
  input  gp_t [GRP_W-1:0] gi,
  input  logic            c0,
  output logic [3:1]      c,
  output gp_t             go
);

  logic [GRP_W-1:0] g;
  logic [GRP_W-1:0] p;

  for (genvar j = 0; j < GRP_W; j++) begin : g_split
    assign g[j] = gi[j].g;
    assign p[j] = gi[j].p;
  end

  // Carries into the upper three inputs, resolved in one step.
  assign c[1] = g[0] | (c0 & p[0]);
  assign c[2] = g[1] | (g[0] & p[1]) | (c0 & p[0] & p[1]);
  assign c[3] = g[2] | (g[1] & p[2]) | (g[0] & p[1] & p[2])
              | (c0 & p[0] & p[1] & p[2]);

  assign go.p = &p;
  assign go.g = g[3] | (g[2] & p[3]) | (g[1] & p[2] & p[3])
              | (g[0] & p[1] & p[2] & p[3]);

  always_comb begin
    if (!$isunknown({gi, c0})) begin
      for (int j = 0; j < 3; j++) begin
        // R3
        lcg_gen_chk: assert ((!g[j] || c[j+1]) && (g[j] || p[j] || !c[j+1]))
          else $error("generator carry %0d ignores generate/kill of its input", j + 1);
      end
    end
  end

endmodule

// File: rtl/cla_core.sv
module cla_core
  import cla_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);

  localparam int NG = W / GRP_W;

  gp_t  [NG-1:0] grp;
  logic [NG-1:0] cg;
  logic [NG-1:0] c3v;
  logic [NG-1:0] c4v;
  gp_t           tp;

  for (genvar k = 0; k < NG; k++) begin : g_grp
    cla_grp4 u_grp (
      .x  (a[GRP_W*k +: GRP_W]),
      .y  (b[GRP_W*k +: GRP_W]),
      .c0 (cg[k]),
      .s  (sum[GRP_W*k +: GRP_W]),
      .c3 (c3v[k]),
      .c4 (c4v[k]),
      .grp(grp[k])
    );
  end

  if (W == 4) begin : g_w4
    assign cg[0] = cin;
    assign tp    = grp[0];
  end else if (W == 16) begin : g_w16
    assign cg[0] = cin;
    cla_lcg4 u_top (
      .gi(grp),
      .c0(cin),
      .c (cg[3:1]),
      .go(tp)
    );
  end else if (W == 64) begin : g_w64
    logic [3:0] cb;
    gp_t  [3:0] qgp;
    assign cb[0] = cin;
    for (genvar q = 0; q < 4; q++) begin : g_quad
      logic [3:1] mid_c;
      cla_lcg4 u_mid (
        .gi(grp[4*q+3 : 4*q]),
        .c0(cb[q]),
        .c (mid_c),
        .go(qgp[q])
      );
      assign cg[4*q]             = cb[q];
      assign cg[4*q+3 : 4*q+1]   = mid_c;
    end
    cla_lcg4 u_top (
      .gi(qgp),
      .c0(cin),
      .c (cb[3:1]),
      .go(tp)
    );
  end else begin : g_bad
    $error("cla_core: W must be 4, 16 or 64");
  end

  assign cout = c4v[NG-1];
  assign ovf  = c4v[NG-1] ^ c3v[NG-1];

  always_comb begin
    if (!$isunknown({a, b, cin})) begin
      for (int k = 0; k < NG; k++) begin
        // R3
        hier_ripple_chk: assert (c4v[k] == ((a[4*k+3] & b[4*k+3])
                                 | ((a[4*k+3] ^ b[4*k+3]) & c3v[k])))
          else $error("group %0d lookahead carry disagrees with ripple step", k);
      end
      for (int k = 0; k < NG - 1; k++) begin
        // R3
        hier_link_chk: assert (c4v[k] == cg[k+1])
          else $error("carry out of group %0d differs from generator carry", k);
      end
      // R3
      hier_top_chk: assert (cout == (tp.g | (tp.p & cin)))
        else $error("top generate/propagate pair does not give carry-out");
    end
  end

endmodule

// File: rtl/cla_adder.sv
module cla_adder #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);

  logic [W-1:0] sum_d;
  logic         cout_d;
  logic         ovf_d;

  cla_core #(.W(W)) u_core (
    .a   (a),
    .b   (b),
    .cin (cin),
    .sum (sum_d),
    .cout(cout_d),
    .ovf (ovf_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum  <= '0;
      cout <= 1'b0;
      ovf  <= 1'b0;
    end else begin
      sum  <= sum_d;
      cout <= cout_d;
      ovf  <= ovf_d;
    end
  end

  // R1
  rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sum == '0 && !cout && !ovf))
    else $error("outputs not cleared by reset");

  // R2
  sum_value_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ({cout, sum} == ({1'b0, $past(a)} + {1'b0, $past(b)}
                                     + (W+1)'($past(cin)))))
    else $error("registered sum/carry wrong");

  // R4
  ovf_sign_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (ovf == (($past(a[W-1]) == $past(b[W-1]))
                             && (sum[W-1] != $past(a[W-1])))))
    else $error("overflow flag disagrees with operand signs");

endmodule

// File: tb/test_cla_adder.sv
module test_cla_adder;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst;

  logic [3:0]  a4,  b4;  logic c4i;
  logic [15:0] a16, b16; logic c16i;
  logic [63:0] a64, b64; logic c64i;

  logic [3:0]  s4;  logic co4,  ov4;
  logic [15:0] s16; logic co16, ov16;
  logic [63:0] s64; logic co64, ov64;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cla_adder #(.W(16)) i_cla_adder (
    .clk(clk), .rst(rst), .a(a16), .b(b16), .cin(c16i),
    .sum(s16), .cout(co16), .ovf(ov16)
  );

  cla_adder #(.W(4)) i_cla_adder_w4 (
    .clk(clk), .rst(rst), .a(a4), .b(b4), .cin(c4i),
    .sum(s4), .cout(co4), .ovf(ov4)
  );

  cla_adder #(.W(64)) i_cla_adder_w64 (
    .clk(clk), .rst(rst), .a(a64), .b(b64), .cin(c64i),
    .sum(s64), .cout(co64), .ovf(ov64)
  );

  task automatic chk(input string tag, input logic [64:0] act, input logic [64:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge capture, check at the next falling edge.
  task automatic step(input logic [3:0] xa4, input logic [3:0] xb4, input logic xc4,
                      input logic [15:0] xa16, input logic [15:0] xb16, input logic xc16,
                      input logic [63:0] xa64, input logic [63:0] xb64, input logic xc64);
    logic [4:0]  e4;
    logic [16:0] e16;
    logic [64:0] e64;
    a4 = xa4;   b4 = xb4;   c4i = xc4;
    a16 = xa16; b16 = xb16; c16i = xc16;
    a64 = xa64; b64 = xb64; c64i = xc64;
    e4  = {1'b0, xa4}  + {1'b0, xb4}  + 5'(xc4);
    e16 = {1'b0, xa16} + {1'b0, xb16} + 17'(xc16);
    e64 = {1'b0, xa64} + {1'b0, xb64} + 65'(xc64);
    @(negedge clk);
    chk("R6/R2 w4 sum",   65'(s4),   65'(e4[3:0]));
    chk("R6/R3 w4 cout",  65'(co4),  65'(e4[4]));
    chk("R6/R4 w4 ovf",   65'(ov4),  65'((xa4[3] == xb4[3]) && (e4[3] != xa4[3])));
    chk("R2 w16 sum",     65'(s16),  65'(e16[15:0]));
    chk("R3 w16 cout",    65'(co16), 65'(e16[16]));
    chk("R4 w16 ovf",     65'(ov16), 65'((xa16[15] == xb16[15]) && (e16[15] != xa16[15])));
    chk("R6/R2 w64 sum",  65'(s64),  65'(e64[63:0]));
    chk("R6/R3 w64 cout", 65'(co64), 65'(e64[64]));
    chk("R6/R4 w64 ovf",  65'(ov64), 65'((xa64[63] == xb64[63]) && (e64[63] != xa64[63])));
  endtask

  task automatic expect_cleared(input string tag);
    chk({tag, " w4"},  65'({s4, co4, ov4}),    65'(0));
    chk({tag, " w16"}, 65'({s16, co16, ov16}), 65'(0));
    chk({tag, " w64"}, 65'({s64, co64, ov64}), 65'(0));
  endtask

  initial begin
    rst = 1'b1;
    a4 = '1;  b4 = '1;  c4i = 1'b1;
    a16 = '1; b16 = '1; c16i = 1'b1;
    a64 = '1; b64 = '1; c64i = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs zero under reset despite all-ones operands
    expect_cleared("R1 reset");
    rst = 1'b0;

    for (int i = 0; i < 512; i++) begin
      logic [15:0] x16, y16;
      logic [63:0] x64, y64;
      logic        k16, k64;
      x16 = 16'($urandom()); y16 = 16'($urandom()); k16 = 1'($urandom());
      x64 = {$urandom(), $urandom()}; y64 = {$urandom(), $urandom()}; k64 = 1'($urandom());
      case (i)
        0: begin x16 = '1; y16 = '0; k16 = 1'b1; x64 = '1; y64 = '0; k64 = 1'b1; end
        1: begin x16 = 16'h7fff; y16 = 16'h1; k16 = 1'b0;
                 x64 = 64'h7fff_ffff_ffff_ffff; y64 = 64'h1; k64 = 1'b0; end
        2: begin x16 = '0; y16 = '0; k16 = 1'b1; x64 = '0; y64 = '0; k64 = 1'b1; end
        3: begin x16 = 16'h8000; y16 = 16'h8000; k16 = 1'b0;
                 x64 = 64'h8000_0000_0000_0000; y64 = 64'h8000_0000_0000_0000; k64 = 1'b0; end
        4: begin x16 = '1; y16 = '1; k16 = 1'b1; x64 = '1; y64 = '1; k64 = 1'b1; end
        5: begin x16 = 16'h0f0f; y16 = 16'hf0f0; k16 = 1'b1;
                 x64 = 64'h0f0f_0f0f_0f0f_0f0f; y64 = 64'hf0f0_f0f0_f0f0_f0f0; k64 = 1'b1; end
        default: ;
      endcase
      step(i[3:0], i[7:4], i[8], x16, y16, k16, x64, y64, k64);
      if (i == 0) begin
        // R5: carry passes through every group
        chk("R5 w16 propagate", 65'({co16, s16}), 65'({1'b1, 16'h0}));
        chk("R5 w64 propagate", 65'({co64, s64}), {1'b1, 64'h0});
      end
      if (i == 1) begin
        // R7: largest positive plus one
        chk("R7 w16 max+1", 65'({co16, ov16, s16}), 65'({1'b0, 1'b1, 16'h8000}));
        chk("R7 w64 max+1", 65'({ov64, s64}),       {1'b1, 64'h8000_0000_0000_0000});
        chk("R7 w64 cout",  65'(co64),              65'(0));
      end
      if (i == 2) begin
        // R8: carry-in alone
        chk("R8 w16 cin only", 65'({co16, ov16, s16}), 65'(1));
        chk("R8 w64 cin only", 65'({co64, ov64}),      65'(0));
        chk("R8 w64 sum",      65'(s64),               65'(1));
      end
    end

    // R1: reset asserted mid-stream with all-ones operands
    rst = 1'b1;
    a4 = '1;  b4 = '1;  c4i = 1'b1;
    a16 = '1; b16 = '1; c16i = 1'b1;
    a64 = '1; b64 = '1; c64i = 1'b1;
    @(negedge clk);
    expect_cleared("R1 mid-run reset");
    rst = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule